// File: doc/BRIEF.md
# Host-to-Controller Doorbell Mailbox

This block is the responder side of a command mailbox between a host processor and a management controller. The host reaches it through a 32-bit word-wide register port that decodes a 256-byte window. Inside the window sit four things: a command word that rings the doorbell, a status word that the host polls, a 16-byte outbound buffer that the host fills before ringing, and a 16-byte inbound buffer that the controller fills with the reply.

The controller sees a one-cycle request strobe together with the decoded command fields. It can read the outbound words by index and load the inbound words by index. It then signals completion with a done strobe that carries an error flag and an 8-bit error code. If the host asked for completion notice in the command word, a single-cycle interrupt pulse goes back to the host. The pulse is edge-type and needs no clearing.

While a command is in flight the mailbox is busy, and further doorbell writes are dropped. The host can therefore poll the busy bit, or wait for the pulse, and then read the status and the reply.

Top module: `mbox_doorbell_top`

## Requirements
- R1: After reset the status word reads busy 0, error 0, command id 0 and error code 0, with the initiator field at bits [15:8] equal to the INIT_ID parameter (default 0x5A). No request strobe and no interrupt is active.
- R2: A host write to offset 0x00 while idle is accepted. On the next cycle busy is 1 and the request strobe is high for exactly one cycle. The outputs then present the opcode from bits [7:0], the completion-notice flag from bit [8], the sub-command id from bits [15:12] and the payload size from bits [23:16].
- R3: Done while busy clears busy on the next cycle and latches the error flag and error code. Done while idle has no effect. Accepting a new command clears the latched error flag and error code.
- R4: A write to offset 0x00 while busy is ignored. The presented command fields, the status word and the request strobe keep their values.
- R5: A host write to offset 0x80+4*i stores the word that the controller reads at outbound index i, for i from 0 to 3.
- R6: When the accepted command had bit [8] set, the interrupt output is high for exactly one cycle, in the cycle after done is accepted. When bit [8] was clear, no pulse occurs.
- R7: A controller load of inbound index i is returned by a host read of offset 0x90+4*i.
- R8: The status word is laid out as busy at bit [0], error at bit [1], command id at bits [7:4], initiator at bits [15:8] and error code at bits [23:16]. All other bits are 0. The command id holds the sub-command id of the accepted command.
- R9: Host reads of the command word, the outbound buffer and unmapped offsets return 0. Host writes to the status word and the inbound buffer change nothing.
- R10: A host read returns its data, with the read-valid output high, in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 8 | Host byte offset within the window |
| hst_wr_en | input | 1 | Host write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rd_en | input | 1 | Host read strobe |
| hst_rdata | output | 32 | Host read data, registered |
| hst_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| host_irq | output | 1 | Completion pulse to the host |
| ctl_req | output | 1 | One-cycle new-command strobe to the controller |
| ctl_opcode | output | 8 | Opcode of the accepted command |
| ctl_ioc | output | 1 | Completion-notice flag of the accepted command |
| ctl_sub | output | 4 | Sub-command id of the accepted command |
| ctl_size | output | 8 | Payload size in bytes |
| ctl_wbuf_idx | input | 2 | Outbound word index read by the controller |
| ctl_wbuf_data | output | 32 | Outbound word at that index |
| ctl_rbuf_we | input | 1 | Inbound word load strobe |
| ctl_rbuf_idx | input | 2 | Inbound word index to load |
| ctl_rbuf_data | input | 32 | Inbound word value |
| ctl_done | input | 1 | Command completion strobe |
| ctl_err | input | 1 | Error flag carried with done |
| ctl_err_code | input | 8 | Error code carried with done |

## Verification
The in-RTL assertions watch the handshake on every cycle. They check that an idle doorbell write sets busy and raises a single-cycle request, and that a write while busy leaves the held command untouched. They also check that done clears busy, that the interrupt never lasts past one cycle, that the command id follows the accepted sub-command, that buffer writes land in the addressed word, and that read-valid trails every read strobe. The bench scenarios are needed for the parts that depend on the address map and the bit layout. These are the exact status word values, zero reads from write-only and unmapped offsets, ignored writes to read-only offsets, the wiring from outbound buffer to controller, the inbound reply path, error clearing on the next command, and whether a pulse appears at all for a given flag value.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int BUF_BYTES = 16;
    localparam int BUF_WORDS = BUF_BYTES / (DATA_W / 8);
    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int WADDR_W   = ADDR_W - 2;

    localparam int OFS_CMD  = 'h00;
    localparam int OFS_STS  = 'h04;
    localparam int OFS_WBUF = 'h80;
    localparam int OFS_RBUF = 'h90;

    typedef struct packed {
        logic [7:0] size;
        logic [3:0] sub;
        logic       ioc;
        logic [7:0] opcode;
    } cmd_t;

    typedef struct packed {
        logic [7:0] code;
        logic [3:0] cmd_id;
        logic       err;
        logic       busy;
    } status_t;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_STS  = 2'd1,
        SEL_RBUF = 2'd2
    } rd_sel_e;

    function automatic cmd_t cmd_from_word(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.size   = w[23:16];
        c.sub    = w[15:12];
        c.ioc    = w[8];
        c.opcode = w[7:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input status_t s,
                                                      input logic [7:0] init_id);
        return {8'h00, s.code, init_id, s.cmd_id, 2'b00, s.err, s.busy};
    endfunction

endpackage

// File: rtl/mbox_host_dec.sv
module mbox_host_dec
    import mbox_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              cmd_wr,
    output logic              wbuf_we,
    output logic [IDX_W-1:0]  idx,
    output rd_sel_e           rd_sel
);
    localparam int CMD_W  = OFS_CMD  >> 2;
    localparam int STS_W  = OFS_STS  >> 2;
    localparam int WBUF_W = OFS_WBUF >> 2;
    localparam int RBUF_W = OFS_RBUF >> 2;

    logic [WADDR_W-1:0] waddr;
    logic               in_wbuf;
    logic               in_rbuf;
    logic               unused_low;

    assign waddr      = addr[ADDR_W-1:2];
    assign unused_low = ^addr[1:0];
    assign idx        = addr[IDX_W+1:2];

    assign in_wbuf = (int'(waddr) >= WBUF_W) && (int'(waddr) < WBUF_W + BUF_WORDS);
    assign in_rbuf = (int'(waddr) >= RBUF_W) && (int'(waddr) < RBUF_W + BUF_WORDS);

    assign cmd_wr  = wr_en && (int'(waddr) == CMD_W);
    assign wbuf_we = wr_en && in_wbuf;

    always_comb begin
        rd_sel = SEL_ZERO;
        if (rd_en) begin
            if (int'(waddr) == STS_W) rd_sel = SEL_STS;
            else if (in_rbuf)         rd_sel = SEL_RBUF;
        end
    end

endmodule

// File: rtl/mbox_regbuf.sv
module mbox_regbuf
    import mbox_pkg::*;
#(
    parameter int WORDS = BUF_WORDS,
    parameter int W     = DATA_W,
    parameter int IW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (we && (int'(widx) == g))
                words[g] <= wdata;
        end
    end

    assign rdata = words[ridx];

    AST_BUF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> words[$past(widx)] == $past(wdata)); // R5

endmodule

// File: rtl/mbox_cmd_ctrl.sv
module mbox_cmd_ctrl
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              err,
    input  logic [7:0]        err_code,
    output cmd_t              cmd_q,
    output status_t           sts_q,
    output logic              req,
    output logic              irq
);
    logic accept;
    logic finish;

    assign accept = cmd_wr && !sts_q.busy;
    assign finish = done && sts_q.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            sts_q <= '0;
            req   <= 1'b0;
            irq   <= 1'b0;
        end else begin
            req <= 1'b0;
            irq <= 1'b0;
            if (accept) begin
                cmd_q        <= cmd_from_word(wdata);
                sts_q.busy   <= 1'b1;
                sts_q.err    <= 1'b0;
                sts_q.code   <= 8'h00;
                sts_q.cmd_id <= wdata[15:12];
                req          <= 1'b1;
            end else if (finish) begin
                sts_q.busy <= 1'b0;
                sts_q.err  <= err;
                sts_q.code <= err_code;
                irq        <= cmd_q.ioc;
            end
        end
    end

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !sts_q.busy) |=> (sts_q.busy && req)); // R2

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req |=> !req); // R2

    AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (sts_q.busy && cmd_wr) |=> ($stable(cmd_q) && !req)); // R4

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sts_q.busy && done) |=> !sts_q.busy); // R3

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R6

    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!sts_q.busy && $past(done))); // R6

    AST_CMDID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !sts_q.busy) |=> sts_q.cmd_id == $past(wdata[15:12])); // R8

endmodule

// File: rtl/mbox_doorbell_top.sv
module mbox_doorbell_top
    import mbox_pkg::*;
#(
    parameter logic [7:0] INIT_ID = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_wr_en,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic              hst_rd_en,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_rvalid,
    output logic              host_irq,
    output logic              ctl_req,
    output logic [7:0]        ctl_opcode,
    output logic              ctl_ioc,
    output logic [3:0]        ctl_sub,
    output logic [7:0]        ctl_size,
    input  logic [IDX_W-1:0]  ctl_wbuf_idx,
    output logic [DATA_W-1:0] ctl_wbuf_data,
    input  logic              ctl_rbuf_we,
    input  logic [IDX_W-1:0]  ctl_rbuf_idx,
    input  logic [DATA_W-1:0] ctl_rbuf_data,
    input  logic              ctl_done,
    input  logic              ctl_err,
    input  logic [7:0]        ctl_err_code
);
    logic              cmd_wr;
    logic              wbuf_we;
    logic [IDX_W-1:0]  hst_idx;
    rd_sel_e           rd_sel;
    cmd_t              cmd_q;
    status_t           sts_q;
    logic [DATA_W-1:0] rbuf_word;
    logic [DATA_W-1:0] rd_mux;

    mbox_host_dec u_dec (
        .addr    (hst_addr),
        .wr_en   (hst_wr_en),
        .rd_en   (hst_rd_en),
        .cmd_wr  (cmd_wr),
        .wbuf_we (wbuf_we),
        .idx     (hst_idx),
        .rd_sel  (rd_sel)
    );

    mbox_cmd_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .wdata    (hst_wdata),
        .done     (ctl_done),
        .err      (ctl_err),
        .err_code (ctl_err_code),
        .cmd_q    (cmd_q),
        .sts_q    (sts_q),
        .req      (ctl_req),
        .irq      (host_irq)
    );

    mbox_regbuf u_wbuf (
        .clk   (clk),
        .rst   (rst),
        .we    (wbuf_we),
        .widx  (hst_idx),
        .wdata (hst_wdata),
        .ridx  (ctl_wbuf_idx),
        .rdata (ctl_wbuf_data)
    );

    mbox_regbuf u_rbuf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_rbuf_we),
        .widx  (ctl_rbuf_idx),
        .wdata (ctl_rbuf_data),
        .ridx  (hst_idx),
        .rdata (rbuf_word)
    );

    assign ctl_opcode = cmd_q.opcode;
    assign ctl_ioc    = cmd_q.ioc;
    assign ctl_sub    = cmd_q.sub;
    assign ctl_size   = cmd_q.size;

    always_comb begin
        unique case (rd_sel)
            SEL_STS:  rd_mux = status_word(sts_q, INIT_ID);
            SEL_RBUF: rd_mux = rbuf_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_rdata  <= '0;
            hst_rvalid <= 1'b0;
        end else begin
            hst_rvalid <= hst_rd_en;
            if (hst_rd_en) hst_rdata <= rd_mux;
        end
    end

    AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        hst_rd_en |=> hst_rvalid); // R10

    AST_IDLE_VALID: assert property (@(posedge clk) disable iff (rst)
        !hst_rd_en |=> !hst_rvalid); // R10

endmodule

// File: tb/mbox_doorbell_top_bench.sv
`timescale 1ns/1ps
module mbox_doorbell_top_bench;
    import mbox_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] hst_addr = '0;
    logic              hst_wr_en = 1'b0;
    logic [DATA_W-1:0] hst_wdata = '0;
    logic              hst_rd_en = 1'b0;
    logic [DATA_W-1:0] hst_rdata;
    logic              hst_rvalid;
    logic              host_irq;
    logic              ctl_req;
    logic [7:0]        ctl_opcode;
    logic              ctl_ioc;
    logic [3:0]        ctl_sub;
    logic [7:0]        ctl_size;
    logic [IDX_W-1:0]  ctl_wbuf_idx = '0;
    logic [DATA_W-1:0] ctl_wbuf_data;
    logic              ctl_rbuf_we = 1'b0;
    logic [IDX_W-1:0]  ctl_rbuf_idx = '0;
    logic [DATA_W-1:0] ctl_rbuf_data = '0;
    logic              ctl_done = 1'b0;
    logic              ctl_err = 1'b0;
    logic [7:0]        ctl_err_code = '0;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit finished = 0;

    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    always #4 clk = ~clk;

    mbox_doorbell_top u_mbox_doorbell_top (
        .clk(clk), .rst(rst),
        .hst_addr(hst_addr), .hst_wr_en(hst_wr_en), .hst_wdata(hst_wdata),
        .hst_rd_en(hst_rd_en), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
        .host_irq(host_irq), .ctl_req(ctl_req), .ctl_opcode(ctl_opcode),
        .ctl_ioc(ctl_ioc), .ctl_sub(ctl_sub), .ctl_size(ctl_size),
        .ctl_wbuf_idx(ctl_wbuf_idx), .ctl_wbuf_data(ctl_wbuf_data),
        .ctl_rbuf_we(ctl_rbuf_we), .ctl_rbuf_idx(ctl_rbuf_idx),
        .ctl_rbuf_data(ctl_rbuf_data), .ctl_done(ctl_done),
        .ctl_err(ctl_err), .ctl_err_code(ctl_err_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: read data lands one cycle after the strobe (R10)
    always @(negedge clk) begin
        if (host_irq) irq_cnt++;
        if (!rst && hst_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected read valid", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, hst_rdata, e);
            end
        end
    end

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr_en = 1'b1;
        @(negedge clk);
        hst_wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        hst_addr = a; hst_rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        hst_rd_en = 1'b0;
    endtask

    task automatic ctl_finish(input logic e, input logic [7:0] code);
        @(negedge clk);
        ctl_done = 1'b1; ctl_err = e; ctl_err_code = code;
        @(negedge clk);
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
    endtask

    task automatic ctl_load(input int i, input logic [31:0] d);
        @(negedge clk);
        ctl_rbuf_we = 1'b1; ctl_rbuf_idx = IDX_W'(i); ctl_rbuf_data = d;
        @(negedge clk);
        ctl_rbuf_we = 1'b0;
    endtask

    function automatic logic [31:0] wpat(input int i);
        return 32'hA5000000 | (i * 32'h00110101);
    endfunction

    function automatic logic [31:0] rpat(input int i);
        return 32'h3C000000 ^ (i * 32'h01020304);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base_irq;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 req after reset", 32'(ctl_req), 0);
        chk("R1 irq after reset", 32'(host_irq), 0);
        host_rd(8'h04, 32'h00005A00, "R1 status after reset");

        // R5 outbound buffer path
        for (int i = 0; i < 4; i++) host_wr(8'(8'h80 + 4*i), wpat(i));
        for (int i = 0; i < 4; i++) begin
            ctl_wbuf_idx = IDX_W'(i);
            #1;
            chk($sformatf("R5 outbound word %0d", i), ctl_wbuf_data, wpat(i));
        end

        // R9 write-only and unmapped reads return zero
        host_rd(8'h80, 32'h0, "R9 read outbound returns zero");
        host_rd(8'h00, 32'h0, "R9 read command returns zero");
        host_rd(8'h40, 32'h0, "R9 read unmapped returns zero");

        // R2 accepted command, no completion notice
        host_wr(8'h00, 32'h000810FF);
        chk("R2 request strobe", 32'(ctl_req), 1);
        chk("R2 opcode", 32'(ctl_opcode), 32'hFF);
        chk("R2 sub id", 32'(ctl_sub), 1);
        chk("R2 size", 32'(ctl_size), 8);
        chk("R2 ioc flag", 32'(ctl_ioc), 0);
        @(negedge clk);
        chk("R2 request single cycle", 32'(ctl_req), 0);
        host_rd(8'h04, 32'h00005A11, "R8 status busy with cmd id");

        // R4 doorbell while busy ignored
        host_wr(8'h00, 32'h000431EE);
        chk("R4 no request while busy", 32'(ctl_req), 0);
        chk("R4 opcode held", 32'(ctl_opcode), 32'hFF);
        chk("R4 sub held", 32'(ctl_sub), 1);
        host_rd(8'h04, 32'h00005A11, "R4 status held while busy");

        // R7 reply, then R3 completion without error, R6 no pulse
        for (int i = 0; i < 4; i++) ctl_load(i, rpat(i));
        base_irq = irq_cnt;
        ctl_finish(1'b0, 8'h00);
        repeat (2) @(negedge clk);
        chk("R6 no pulse without flag", 32'(irq_cnt - base_irq), 0);
        host_rd(8'h04, 32'h00005A10, "R3 busy clears on done");
        for (int i = 0; i < 4; i++)
            host_rd(8'(8'h90 + 4*i), rpat(i), $sformatf("R7 inbound word %0d", i));

        // R9 writes to read-only locations
        host_wr(8'h90, 32'hDEADBEEF);
        host_wr(8'h04, 32'hFFFFFFFF);
        host_rd(8'h90, rpat(0), "R9 inbound write ignored");
        host_rd(8'h04, 32'h00005A10, "R9 status write ignored");

        // R6 completion notice, R3 error latched
        host_wr(8'h00, 32'h000421EF);
        chk("R2 ioc flag set", 32'(ctl_ioc), 1);
        base_irq = irq_cnt;
        ctl_finish(1'b1, 8'h33);
        chk("R6 pulse in cycle after done", 32'(host_irq), 1);
        @(negedge clk);
        chk("R6 pulse is one cycle", 32'(host_irq), 0);
        chk("R6 exactly one pulse", 32'(irq_cnt - base_irq), 1);
        host_rd(8'h04, 32'h00335A22, "R3 error and code latched");

        // R3 done while idle has no effect
        base_irq = irq_cnt;
        ctl_finish(1'b0, 8'h77);
        repeat (2) @(negedge clk);
        chk("R3 idle done no pulse", 32'(irq_cnt - base_irq), 0);
        host_rd(8'h04, 32'h00335A22, "R3 idle done ignored");

        // R3 next command clears error
        host_wr(8'h00, 32'h00003001);
        host_rd(8'h04, 32'h00005A31, "R3 accept clears error");
        ctl_finish(1'b0, 8'h00);
        host_rd(8'h04, 32'h00005A30, "R3 clean completion");

        repeat (3) @(negedge clk);
        chk("R10 all reads returned", 32'(exp_q.size()), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule